// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets the CPUs of a small multiprocessor signal one another. Every CPU owns a private first-in first-out queue of pending interrupt numbers. Any CPU may post a number either to one chosen CPU or to every CPU but one. A CPU collects its own messages one at a time by reading a single register, and it may discard everything still waiting for it with a single write. Each CPU has a dedicated interrupt line that stays high for as long as its queue holds at least one entry.

Access is through a simple register bus. Every request carries the id of the CPU making it, and that id selects the queue for pops, flushes and the overflow flag. Read data returns on the cycle after the request. Two further read-only registers give the requester its own id and the number of CPUs in the system.

Top module: `ipi_mailbox`

## Requirements
- R1: A write to offset 0xA0 posts to one CPU. Bits [31:16] of the write data hold the interrupt number and bits [15:0] hold the target id. The number is appended at the tail of the target's queue.
- R2: A write to offset 0xB0 uses the same field layout as R1. It appends the number to the queue of every CPU except the CPU named in bits [15:0].
- R3: A read of offset 0xC0 returns the oldest entry in the requester's queue and removes it. Entries come back in the order they were posted. The read returns 0 when the queue is empty. For every read, rsp_valid is high with the data exactly one cycle after the request; writes produce no response.
- R4: A write of any value to offset 0xC0 empties the requester's queue and leaves every other queue unchanged.
- R5: irq[i] is high exactly while CPU i's queue is non-empty. It reflects a request from the cycle after that request.
- R6: A read of offset 0x00 returns the requester's id. A read of offset 0x10 returns the number of CPUs.
- R7: A queue holds DEPTH entries. A post to a full queue is dropped and sets a sticky overflow flag for that CPU. Reading offset 0xD0 returns the requester's flag in bit 0. The flag is cleared when that CPU flushes its queue.
- R8: A single-target post whose target id is not below NCPU is ignored. An all-but-one post that names an out-of-range id reaches every CPU.
- R9: A post carrying interrupt number 0 changes no queue.
- R10: After reset every queue is empty, every overflow flag is clear and every irq bit is low.
- R11: A read of any other offset returns 0. A write to any other offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register offset |
| req_wdata | input | 32 | Write data |
| req_cpu | input | CIDW | Id of the requesting CPU |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| irq | output | NCPU | One interrupt line per CPU, high while its queue is non-empty |

## Verification
The hardest state to reach is a full queue that then receives further posts. Reaching it takes more posts than the queue depth, all aimed at one CPU with no pop in between. Once the queue is full, the test must show three things through the ports: the extra numbers are dropped and never come back from a pop, the overflow flag of that CPU alone is set, and the following flush clears both the queue and the flag. The stimulus builds this state with a burst of single-target posts and mixes in all-but-one posts to fill neighbouring queues. A reference queue per CPU in the bench predicts every popped value, so ordering errors and lost or duplicated entries show up as mismatches.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int IPI_NUM_W = 16;
    localparam int IPI_TGT_W = 16;
    localparam int BUS_DW    = 32;
    localparam int BUS_AW    = 8;

    // Register offsets
    localparam logic [BUS_AW-1:0] OFS_SELF_ID = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_NUM_CPU = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_POST1   = 8'hA0;
    localparam logic [BUS_AW-1:0] OFS_POSTX   = 8'hB0;
    localparam logic [BUS_AW-1:0] OFS_QUEUE   = 8'hC0;
    localparam logic [BUS_AW-1:0] OFS_OVFLAG  = 8'hD0;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SELF,
        OP_NCPU,
        OP_POST,
        OP_POP,
        OP_FLUSH,
        OP_OVF
    } mbx_op_e;

    typedef struct packed {
        logic [IPI_NUM_W-1:0] num;
        logic [IPI_TGT_W-1:0] tgt;
    } post_word_t;

    function automatic post_word_t split_post(input logic [BUS_DW-1:0] w);
        return post_word_t'(w);
    endfunction

endpackage

// File: rtl/ipi_fifo.sv
module ipi_fifo
    import ipi_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = IPI_NUM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] head,
    output logic         nonempty,
    output logic         drop
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          full, empty, do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign drop    = push && !do_push;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= step(wr_q);
            if (do_pop)  rd_q <= step(rd_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_q] <= push_data;
    end

    assign head     = mem[rd_q];
    assign nonempty = !empty;

endmodule

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [BUS_AW-1:0]    req_addr,
    input  logic [BUS_DW-1:0]    req_wdata,
    output mbx_op_e              op,
    output logic [NCPU-1:0]      push_mask,
    output logic [IPI_NUM_W-1:0] push_num
);
    post_word_t pw;
    logic       is_one, is_all;

    assign pw       = split_post(req_wdata);
    assign push_num = pw.num;
    assign is_one   = req_valid && req_write && (req_addr == OFS_POST1);
    assign is_all   = req_valid && req_write && (req_addr == OFS_POSTX);

    always_comb begin
        op = OP_IDLE;
        if (req_valid) begin
            if (req_write) begin
                case (req_addr)
                    OFS_POST1, OFS_POSTX: op = OP_POST;
                    OFS_QUEUE:            op = OP_FLUSH;
                    default:              op = OP_IDLE;
                endcase
            end else begin
                case (req_addr)
                    OFS_SELF_ID: op = OP_SELF;
                    OFS_NUM_CPU: op = OP_NCPU;
                    OFS_QUEUE:   op = OP_POP;
                    OFS_OVFLAG:  op = OP_OVF;
                    default:     op = OP_IDLE;
                endcase
            end
        end
    end

    // Out-of-range ids match no CPU: single posts vanish, all-but-one posts reach all.
    for (genvar i = 0; i < NCPU; i++) begin : g_hit
        logic id_match;
        assign id_match     = (pw.tgt == IPI_TGT_W'(i));
        assign push_mask[i] = (pw.num != '0) &&
                              ((is_one && id_match) || (is_all && !id_match));
    end

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
    import ipi_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int DEPTH = 8,
    localparam int CIDW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [CIDW-1:0]   req_cpu,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [NCPU-1:0]   irq
);
    mbx_op_e              op;
    logic [NCPU-1:0]      push_mask;
    logic [IPI_NUM_W-1:0] push_num;
    logic [IPI_NUM_W-1:0] head [NCPU];
    logic [NCPU-1:0]      nonempty, drop, ovf_q, is_req;
    logic [IPI_NUM_W-1:0] sel_head;
    logic                 sel_ne, sel_ovf;
    logic [BUS_DW-1:0]    rd_data;

    ipi_decode #(.NCPU(NCPU)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .op        (op),
        .push_mask (push_mask),
        .push_num  (push_num)
    );

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        assign is_req[i] = (req_cpu == CIDW'(i));

        ipi_fifo #(.DEPTH(DEPTH), .W(IPI_NUM_W)) u_q (
            .clk       (clk),
            .rst       (rst),
            .push      (push_mask[i]),
            .push_data (push_num),
            .pop       (op == OP_POP && is_req[i]),
            .flush     (op == OP_FLUSH && is_req[i]),
            .head      (head[i]),
            .nonempty  (nonempty[i]),
            .drop      (drop[i])
        );

        always_ff @(posedge clk) begin
            if (rst || (op == OP_FLUSH && is_req[i])) ovf_q[i] <= 1'b0;
            else if (drop[i])                         ovf_q[i] <= 1'b1;
        end
    end

    always_comb begin
        sel_head = '0;
        sel_ne   = 1'b0;
        sel_ovf  = 1'b0;
        for (int i = 0; i < NCPU; i++) begin
            if (is_req[i]) begin
                sel_head = head[i];
                sel_ne   = nonempty[i];
                sel_ovf  = ovf_q[i];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (op)
            OP_SELF: rd_data = BUS_DW'(req_cpu);
            OP_NCPU: rd_data = BUS_DW'(NCPU);
            OP_POP:  rd_data = sel_ne ? BUS_DW'(sel_head) : '0;
            OP_OVF:  rd_data = BUS_DW'(sel_ovf);
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= rd_data;
        end
    end

    assign irq = nonempty;

endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk #(
    parameter int NCPU  = 4,
    parameter int CIDW  = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_write,
    input logic [7:0]      req_addr,
    input logic [31:0]     req_wdata,
    input logic [CIDW-1:0] req_cpu,
    input logic            rsp_valid,
    input logic [31:0]     rsp_rdata,
    input logic [NCPU-1:0] irq
);
    logic rd_req;
    assign rd_req = req_valid && !req_write;

    a_r3_rsp_timing: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rsp_valid == $past(rd_req)));

    a_r6_self_id: assert property (@(posedge clk) disable iff (rst)
        (rd_req && req_addr == 8'h00) |=> (rsp_rdata == 32'($past(req_cpu))));

    a_r6_num_cpu: assert property (@(posedge clk) disable iff (rst)
        (rd_req && req_addr == 8'h10) |=> (rsp_rdata == 32'(NCPU)));

    a_r11_other_read: assert property (@(posedge clk) disable iff (rst)
        (rd_req && req_addr == 8'h40) |=> (rsp_rdata == 32'd0));

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        a_r1_post_raises: assert property (@(posedge clk) disable iff (rst)
            (req_valid && req_write && req_addr == 8'hA0 &&
             req_wdata[15:0] == 16'(i) && req_wdata[31:16] != 16'd0) |=> irq[i]);

        a_r4_flush_clears: assert property (@(posedge clk) disable iff (rst)
            (req_valid && req_write && req_addr == 8'hC0 &&
             req_cpu == CIDW'(i)) |=> !irq[i]);

        a_r3_empty_pop_zero: assert property (@(posedge clk) disable iff (rst)
            (rd_req && req_addr == 8'hC0 && req_cpu == CIDW'(i) && !irq[i])
            |=> (rsp_rdata == 32'd0));

        a_r5_rise_needs_post: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[i]) |-> $past(req_valid && req_write &&
                                    (req_addr == 8'hA0 || req_addr == 8'hB0)));
    end

endmodule

bind ipi_mailbox ipi_mailbox_chk #(.NCPU(NCPU), .CIDW(CIDW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_cpu   (req_cpu),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq       (irq)
);

// File: tb/ipi_mailbox_tb.sv
module ipi_mailbox_tb;
    localparam int NCPU  = 4;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_cpu   = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [NCPU-1:0] irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int    mq [NCPU][$];
    bit    movf [NCPU];
    int    exp_val [$];
    string exp_tag [$];

    always #2 clk = ~clk;

    ipi_mailbox #(.NCPU(NCPU), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares every response against the scoreboard
    always @(negedge clk) begin
        if (!rst && rsp_valid && !done) begin
            if (exp_val.size() == 0) begin
                check("R3 unexpected response", 1, 0);
            end else begin
                check(exp_tag.pop_front(), int'(rsp_rdata), exp_val.pop_front());
            end
        end
    end

    task automatic bus(input bit w, input logic [7:0] a, input logic [31:0] d, input int cpu);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        req_cpu   = 2'(cpu);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic int model_irq();
        int v = 0;
        for (int i = 0; i < NCPU; i++) if (mq[i].size() != 0) v |= (1 << i);
        return v;
    endfunction

    task automatic check_irq(input string tag);
        check(tag, int'(irq), model_irq());
    endtask

    task automatic post(input int num, input int tgt, input bit all, input int src);
        for (int i = 0; i < NCPU; i++) begin
            bit hit = all ? (i != tgt) : (i == tgt);
            if (num != 0 && hit) begin
                if (mq[i].size() < DEPTH) mq[i].push_back(num);
                else movf[i] = 1;
            end
        end
        bus(1'b1, all ? 8'hB0 : 8'hA0, {num[15:0], tgt[15:0]}, src);
    endtask

    task automatic pop(input int cpu, input string tag);
        exp_val.push_back(mq[cpu].size() != 0 ? mq[cpu].pop_front() : 0);
        exp_tag.push_back(tag);
        bus(1'b0, 8'hC0, 32'd0, cpu);
    endtask

    task automatic rd(input logic [7:0] a, input int cpu, input int exp, input string tag);
        exp_val.push_back(exp);
        exp_tag.push_back(tag);
        bus(1'b0, a, 32'd0, cpu);
    endtask

    task automatic flush(input int cpu);
        mq[cpu].delete();
        movf[cpu] = 0;
        bus(1'b1, 8'hC0, 32'hDEAD_BEEF, cpu);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 irq after reset", int'(irq), 0);
        check("R10 no response after reset", int'(rsp_valid), 0);
        pop(0, "R10 pop empty after reset");
        rd(8'hD0, 3, 0, "R10 overflow clear after reset");

        // R6: identity and CPU count
        for (int c = 0; c < NCPU; c++) rd(8'h00, c, c, "R6 self id");
        rd(8'h10, 2, NCPU, "R6 cpu count");

        // R1 / R3 / R5: single-target post and FIFO order
        post(5, 2, 0, 0);
        check_irq("R5 irq after single post");
        pop(2, "R1 pop single entry");
        check_irq("R5 irq drops when queue empties");
        pop(2, "R3 pop empty returns zero");
        post(7, 1, 0, 3);
        post(8, 1, 0, 0);
        post(16'hFFFF, 1, 0, 2);
        check_irq("R5 irq with three entries");
        pop(1, "R3 order first");
        pop(1, "R3 order second");
        pop(1, "R3 order third");
        check_irq("R5 irq after draining");

        // R2: all-but-one
        post(16'h33, 1, 1, 1);
        check_irq("R2 irq on all but named CPU");
        pop(0, "R2 cpu0 gets broadcast");
        pop(1, "R2 named cpu excluded");
        pop(2, "R2 cpu2 gets broadcast");
        pop(3, "R2 cpu3 gets broadcast");

        // R8: out-of-range ids
        post(9, 9, 0, 0);
        check_irq("R8 single post to missing CPU ignored");
        post(16'h44, 16'hFFFF, 1, 0);
        check_irq("R8 out-of-range exclusion reaches all");
        for (int c = 0; c < NCPU; c++) pop(c, "R8 broadcast entry");

        // R9: number zero
        post(0, 3, 0, 0);
        post(0, 0, 1, 0);
        check_irq("R9 number zero ignored");
        pop(3, "R9 no entry from number zero");

        // R4: flush only own queue
        post(21, 0, 0, 1);
        post(22, 0, 0, 1);
        post(23, 3, 0, 1);
        check_irq("R4 setup");
        flush(0);
        check_irq("R4 flush empties only requester");
        pop(0, "R4 flushed queue empty");
        pop(3, "R4 other queue kept");

        // R7: overflow
        for (int k = 1; k <= DEPTH + 2; k++) post(100 + k, 2, 0, 0);
        post(16'h55, 2, 1, 2);
        rd(8'hD0, 2, 1, "R7 overflow flag set");
        rd(8'hD0, 1, 0, "R7 overflow flag of other CPU clear");
        for (int k = 0; k < DEPTH; k++) pop(2, "R7 kept entries in order");
        pop(2, "R7 dropped entries never return");
        rd(8'hD0, 2, 1, "R7 flag sticky after drain");
        flush(2);
        rd(8'hD0, 2, 0, "R7 flag cleared by flush");
        flush(0); flush(1); flush(3);
        check_irq("R7 all queues empty");

        // R11: unmapped offsets
        post(77, 1, 0, 0);
        bus(1'b1, 8'h40, 32'h004D_0001, 1);
        check_irq("R11 unmapped write no effect");
        rd(8'h40, 1, 0, "R11 unmapped read zero");
        pop(1, "R11 queue untouched by unmapped write");
        pop(1, "R11 queue now empty");

        repeat (3) @(negedge clk);
        check("R3 all responses seen", exp_val.size(), 0);
        finish_run();
    end

endmodule